// File: doc/BRIEF.md
# Receive Output Formatter with Odd Parity

This block drives the receive-side output register of a serial link: eight data signals, three status signals and one parity signal. In decoded mode the register is loaded from a decoded byte and its three-bit receive status. In bypass mode the same eleven signals carry a raw framed 10-bit code group together with a flag that marks a framing-character match. The decoder and the framer sit upstream and feed this block.

An odd-parity bit is loaded together with the data and status. It can be switched off, or it can cover a narrow or a wide set of bits. Which bits each set holds depends on the mode. All outputs are registered on the output clock, so each change shows one cycle after the inputs that cause it.

Top module: `rx_out_fmt`

## Requirements
- R1: While the active-low reset `rstN` is low, `dataOut`, `statOut` and `parOut` are all 0.
- R2: With `bypassMode` = 0, `dataOut` takes `decByte` and `statOut` takes `decStat` with no change to bit order.
- R3: With `bypassMode` = 1, `statOut[0]` takes `frameHit`, `statOut[2:1]` takes `rawChar[1:0]` and `dataOut` takes `rawChar[9:2]`. Seen as one 11-bit word {dataOut, statOut}, this equals {rawChar, frameHit}.
- R4: The raw bits rawChar[0] through rawChar[9] are the code-group letters a, b, c, d, e, i, f, g, h, j in that order. Letter i (rawChar[5]) therefore appears on `dataOut[3]` and letter j on `dataOut[7]`.
- R5: `parSel` encoding: 2'b00 means parity off, 2'b01 selects the narrow set, and 2'b10 or 2'b11 selects the wide set. With parity off, `parOut` is 0.
- R6: Decoded mode, narrow set: `dataOut` together with `parOut` holds an odd number of ones.
- R7: Decoded mode, wide set: `dataOut`, all of `statOut` and `parOut` together hold an odd number of ones.
- R8: Bypass mode, narrow set: `dataOut`, `statOut[2:1]` and `parOut` together hold an odd number of ones. The framing flag in `statOut[0]` has no effect on `parOut`.
- R9: Bypass mode, wide set: `dataOut`, all of `statOut` (framing flag included) and `parOut` together hold an odd number of ones.
- R10: Data, status and parity appear on the outputs together, exactly one clock edge after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bypassMode | input | 1 | 0: decoded byte and status, 1: raw code group and framing flag |
| decByte | input | 8 | Decoded data byte |
| decStat | input | 3 | Decoded receive status |
| rawChar | input | 10 | Raw framed code group, bit 0 = letter a |
| frameHit | input | 1 | Framing-character match for rawChar |
| parSel | input | 2 | Parity coverage select |
| dataOut | output | 8 | Registered data field |
| statOut | output | 3 | Registered status field |
| parOut | output | 1 | Registered odd-parity bit |

## Verification
On every cycle, the assertions compare the registered word with the inputs from the cycle before, in both modes. They also check the odd count over the set of bits that the previous `parSel` and mode selected, and that `parOut` is low when parity is off. The count checks cover R5 through R10 without reference to a model. Only the bench scenarios can show the reset value and the letter placement of single raw bits. They also show that the framing flag is left out of the narrow bypass set, tested with all-zero data where the flag alone would flip the parity.

// File: rtl/rx_out_fmt_pkg.sv
package rx_out_fmt_pkg;
  // Parity coverage select encoding
  typedef enum logic [1:0] {
    PAR_OFF    = 2'b00,
    PAR_NARROW = 2'b01,
    PAR_WIDE   = 2'b10,
    PAR_WIDE2  = 2'b11
  } parSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic selRaw;    // load raw code group instead of decoded byte
    logic parEn;     // parity generation enabled
    logic covLow;    // status bit 0 is covered by parity
    logic covHigh;   // upper status bits are covered by parity
  } fmtCtl_t;
endpackage

// File: rtl/rx_out_fmt_ctl.sv
module rx_out_fmt_ctl
  import rx_out_fmt_pkg::*;
(
  input  logic       bypassMode,
  input  logic [1:0] parSel,
  output fmtCtl_t    ctl
);
  logic isWide;
  logic isNarrow;

  always_comb begin
    isWide   = parSel[1];
    isNarrow = (parSel == PAR_NARROW);
    ctl.selRaw  = bypassMode;
    ctl.parEn   = (parSel != PAR_OFF);
    // Wide set covers every status bit in both modes.
    // Narrow set in bypass still covers the two raw-bit status positions.
    ctl.covLow  = isWide;
    ctl.covHigh = isWide | (isNarrow & bypassMode);
  end
endmodule

// File: rtl/rx_out_fmt_dp.sv
module rx_out_fmt_dp
  import rx_out_fmt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtCtl_t           ctl,
  input  logic [DATA_W-1:0] decByte,
  input  logic [STAT_W-1:0] decStat,
  input  logic [DATA_W+STAT_W-2:0] rawChar,
  input  logic              frameHit,
  output logic [DATA_W-1:0] dataOut,
  output logic [STAT_W-1:0] statOut,
  output logic              parOut
);
  localparam int WORD_W = DATA_W + STAT_W;

  logic [WORD_W-1:0] nextWord;
  logic [STAT_W-1:0] statMask;
  logic [WORD_W-1:0] covered;
  logic              nextPar;

  // Per-bit status coverage: bit 0 is the flag position, the rest are upper
  for (genvar gi = 0; gi < STAT_W; gi++) begin : g_mask
    if (gi == 0) begin : g_low
      assign statMask[gi] = ctl.covLow;
    end else begin : g_high
      assign statMask[gi] = ctl.covHigh;
    end
  end

  always_comb begin
    nextWord = ctl.selRaw ? {rawChar, frameHit} : {decByte, decStat};
    covered  = {nextWord[WORD_W-1:STAT_W], nextWord[STAT_W-1:0] & statMask};
    nextPar  = ctl.parEn & ~(^covered);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      statOut <= '0;
      parOut  <= 1'b0;
    end else begin
      dataOut <= nextWord[WORD_W-1:STAT_W];
      statOut <= nextWord[STAT_W-1:0];
      parOut  <= nextPar;
    end
  end
endmodule

// File: rtl/rx_out_fmt.sv
module rx_out_fmt
  import rx_out_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bypassMode,
  input  logic [7:0] decByte,
  input  logic [2:0] decStat,
  input  logic [9:0] rawChar,
  input  logic       frameHit,
  input  logic [1:0] parSel,
  output logic [7:0] dataOut,
  output logic [2:0] statOut,
  output logic       parOut
);
  fmtCtl_t ctl;

  rx_out_fmt_ctl u_ctl (
    .bypassMode (bypassMode),
    .parSel     (parSel),
    .ctl        (ctl)
  );

  rx_out_fmt_dp #(.DATA_W(8), .STAT_W(3)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .decByte  (decByte),
    .decStat  (decStat),
    .rawChar  (rawChar),
    .frameHit (frameHit),
    .dataOut  (dataOut),
    .statOut  (statOut),
    .parOut   (parOut)
  );
endmodule

// File: rtl/rx_out_fmt_chk.sv
module rx_out_fmt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bypassMode,
  input logic [7:0] decByte,
  input logic [2:0] decStat,
  input logic [9:0] rawChar,
  input logic       frameHit,
  input logic [1:0] parSel,
  input logic [7:0] dataOut,
  input logic [2:0] statOut,
  input logic       parOut
);
  // R2 and R10: decoded word appears one edge later
  a_r2_decoded_load: assert property (@(posedge clk) disable iff (!rstN)
    !bypassMode |=> {dataOut, statOut} == {$past(decByte), $past(decStat)});

  // R3 and R10: raw word plus framing flag appears one edge later
  a_r3_bypass_load: assert property (@(posedge clk) disable iff (!rstN)
    bypassMode |=> {dataOut, statOut} == {$past(rawChar), $past(frameHit)});

  // R5: parity off forces a low parity bit
  a_r5_par_off: assert property (@(posedge clk) disable iff (!rstN)
    (parSel == 2'b00) |=> !parOut);

  // R6
  a_r6_dec_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassMode && parSel == 2'b01) |=> (^{dataOut, parOut}));

  // R7 and R9: wide set covers all eleven bits in either mode
  a_r7_wide_odd: assert property (@(posedge clk) disable iff (!rstN)
    parSel[1] |=> (^{dataOut, statOut, parOut}));

  // R8
  a_r8_byp_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (bypassMode && parSel == 2'b01) |=> (^{dataOut, statOut[2:1], parOut}));
endmodule

bind rx_out_fmt rx_out_fmt_chk u_chk (.*);

// File: tb/sim_rx_out_fmt.sv
module sim_rx_out_fmt;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bypassMode = 1'b0;
  logic [7:0] decByte = '0;
  logic [2:0] decStat = '0;
  logic [9:0] rawChar = '0;
  logic       frameHit = 1'b0;
  logic [1:0] parSel = '0;
  logic [7:0] dataOut;
  logic [2:0] statOut;
  logic       parOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_out_fmt u0 (.*);

  // Expected 11-bit word per R2/R3
  function automatic logic [10:0] expWord(logic byp, logic [7:0] db, logic [2:0] ds,
                                          logic [9:0] rc, logic fh);
    return byp ? {rc, fh} : {db, ds};
  endfunction

  // Expected parity per R5..R9
  function automatic logic expPar(logic byp, logic [1:0] ps, logic [10:0] w);
    logic [10:0] m;
    if (ps == 2'b00) return 1'b0;
    if (ps[1])       m = 11'h7FF;
    else if (byp)    m = 11'h7FE;
    else             m = 11'h7F8;
    return ~(^(w & m));
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  // Drive at negedge, check at the following negedge (one edge of latency, R10)
  task automatic apply(string req, logic byp, logic [7:0] db, logic [2:0] ds,
                       logic [9:0] rc, logic fh, logic [1:0] ps);
    logic [10:0] w;
    bypassMode = byp; decByte = db; decStat = ds;
    rawChar = rc; frameHit = fh; parSel = ps;
    w = expWord(byp, db, ds, rc, fh);
    @(negedge clk);
    chk(req, {dataOut, statOut, parOut}, {w, expPar(byp, ps, w)});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    decByte = 8'hFF; decStat = 3'h7; parSel = 2'b10;
    repeat (3) @(negedge clk);
    chk("R1 reset", {dataOut, statOut, parOut}, 12'h000);
    rstN = 1'b1;

    // R2 decoded pass-through, R6/R7 parity
    apply("R2 R6 dec narrow", 1'b0, 8'hA5, 3'b101, 10'h000, 1'b0, 2'b01);
    apply("R2 R7 dec wide",   1'b0, 8'hA5, 3'b101, 10'h000, 1'b0, 2'b10);
    apply("R6 zero byte status ignored", 1'b0, 8'h00, 3'b111, 10'h3FF, 1'b1, 2'b01);
    apply("R7 all zero",      1'b0, 8'h00, 3'b000, 10'h3FF, 1'b1, 2'b11);
    apply("R5 off",           1'b0, 8'h00, 3'b000, 10'h000, 1'b0, 2'b00);
    // R3/R4 bypass placement
    apply("R4 letter i",      1'b1, 8'hFF, 3'b111, 10'h020, 1'b0, 2'b00);
    apply("R4 letter j",      1'b1, 8'h00, 3'b000, 10'h200, 1'b0, 2'b00);
    apply("R4 letter a",      1'b1, 8'h00, 3'b000, 10'h001, 1'b0, 2'b00);
    apply("R3 flag only",     1'b1, 8'h00, 3'b000, 10'h000, 1'b1, 2'b00);
    // R8 flag excluded, R9 flag included
    apply("R8 flag excluded", 1'b1, 8'h00, 3'b000, 10'h000, 1'b1, 2'b01);
    apply("R9 flag included", 1'b1, 8'h00, 3'b000, 10'h000, 1'b1, 2'b10);
    apply("R8 raw low bits",  1'b1, 8'h00, 3'b000, 10'h002, 1'b0, 2'b01);

    // Constrained random mix (fixed seed)
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [1:0] ps;
      ps = 2'($urandom_range(0, 3));
      apply("R10 random", 1'($urandom), 8'($urandom), 3'($urandom),
            10'($urandom), 1'($urandom), ps);
    end

    // R1 again mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", {dataOut, statOut, parOut}, 12'h000);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule